// File: doc/BRIEF.md
# Flash Erase and Write Control Front End

This block sits between an 8-bit microcontroller's special-function-register bus and an embedded flash controller. Software uses its registers to choose a page, a bank and a write mode, and to arm either a page erase or a whole-array erase. It then writes the erase-trigger register, and the block turns that write into a single-cycle start pulse toward the flash array. Every arming value is used once. An erase consumes it, so each new erase needs a fresh write.

External-data writes from the processor are steered by a program-write mode bit. With the bit clear they go to data RAM. With it set they become flash write requests, and the bank select supplies the upper address bits. A set-only security latch blanks the external read-out path. Two sticky flags record flash writes that collide with a companion compute engine, either while it is busy or on the cycle it starts a code pass. While an erase is running, a busy output holds off further triggers and flash writes until the array signals done.

Top module: `flash_sfr_ctl`

## Requirements
- R1: After reset the register reads are: control 0x10 = {preboot, 7'b0}, page 0x11 = 0, bank 0x12 = 0, flags 0x14 = 0. `erase_busy` and both start pulses are 0. Unmapped addresses read 0.
- R2: A write to the page register (0x11, bits 6:0 = page 0..127) stores the page, reads back the stored value and arms a page erase. A write to the trigger register 0x13 with only a page armed raises `page_erase_start` for exactly one cycle, in the cycle after the write. `erase_page` holds the page at that time.
- R3: A page erase consumes the page arming. A later trigger with no new page write produces no pulse.
- R4: Control bit 1 (mass-erase enable) arms a mass erase and reads back as set. A trigger with it set raises `mass_erase_start` for one cycle instead of a page pulse, even when a page is also armed. The bit then reads 0. A page arming that is still pending survives for a later trigger.
- R5: A trigger with nothing armed produces no pulse and leaves `erase_busy` at 0.
- R6: `erase_busy` rises in the same cycle as a start pulse and falls after a cycle with `erase_done` high. While it is high, triggers produce no pulse and leave the arming unchanged, and flash writes produce no request.
- R7: A processor write (`xw_en`) with control bit 0 (program-write) at 0 gives a one-cycle `ram_we` in the next cycle. With bit 0 at 1 it gives `flash_wr_req` instead. `wr_data` carries the byte and `wr_addr` = {bank, `xw_addr`}.
- R8: The bank register (0x12, bits 2:0) reads back what was written and forms the upper bits of `wr_addr`.
- R9: Control bit 6 (security) can be set by software but clears only on reset; writing 0 to it has no effect. While it is set, `ext_rd_data` is 0x00; otherwise it equals `flash_rd_data`.
- R10: Flags bit 0 becomes 1 in the cycle after a `flash_wr_req` cycle in which `ce_busy` was high.
- R11: Flags bit 1 becomes 1 in the cycle after a processor write with program-write set that coincides with `ce_pass_start`.
- R12: The flags stay set until software writes 0 to that bit of 0x14. Writing 1 leaves a bit unchanged.
- R13: Control bit 7 reads the `preboot` input and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| xw_en | input | 1 | Processor external-data write strobe |
| xw_addr | input | XA_W | External-data write address |
| xw_data | input | 8 | External-data write byte |
| ram_we | output | 1 | Data RAM write strobe |
| flash_wr_req | output | 1 | Flash byte program request |
| wr_addr | output | BANK_W+XA_W | Write address, bank on top |
| wr_data | output | 8 | Write byte |
| erase_page | output | PAGE_W | Page selected for erase |
| page_erase_start | output | 1 | One-cycle page erase start |
| mass_erase_start | output | 1 | One-cycle mass erase start |
| erase_busy | output | 1 | Erase in progress |
| erase_done | input | 1 | Erase completion from flash array |
| ce_busy | input | 1 | Compute engine busy |
| ce_pass_start | input | 1 | Compute engine starting a code pass |
| preboot | input | 1 | Pre-boot sequence active |
| flash_rd_data | input | 8 | Flash read-out data |
| ext_rd_data | output | 8 | Read-out data seen by the external port |

## Verification
The bench uses the default parameters, PAGE_W = 7 and BANK_W = 3. The 7-bit page field gives 128 pages, and every page is erased once and then re-triggered to confirm that its arming was consumed. The 3-bit bank field is swept across all eight values, with a flash write at each, so that every upper-address pattern on `wr_addr` is compared against an address the bench builds itself. The mass and page arming orderings, the busy window and both collision flags are each driven through their corner cases, and the register reads are compared with values the bench assembles from the bit positions given in the requirements.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_PAGE  = 8'h11;
  localparam logic [7:0] A_BANK  = 8'h12;
  localparam logic [7:0] A_TRIG  = 8'h13;
  localparam logic [7:0] A_FLAGS = 8'h14;

  localparam int CB_PWE    = 0;
  localparam int CB_MASS   = 1;
  localparam int CB_SECURE = 6;
  localparam int CB_PREBT  = 7;

  typedef enum logic [1:0] {ER_NONE, ER_PAGE, ER_MASS} erase_kind_e;

  // Decide what a trigger write starts; mass arming wins over page arming.
  function automatic erase_kind_e pick_erase(input logic trig, input logic busy,
                                             input logic mass_armed, input logic page_armed);
    if (!trig || busy)   return ER_NONE;
    else if (mass_armed) return ER_MASS;
    else if (page_armed) return ER_PAGE;
    else                 return ER_NONE;
  endfunction

  // Sticky flags: a software write keeps a bit only where it writes 1; hardware sets win.
  function automatic logic [1:0] flag_next(input logic [1:0] cur, input logic sw_wr,
                                           input logic [1:0] sw_data, input logic [1:0] hw_set);
    logic [1:0] v;
    v = sw_wr ? (cur & sw_data) : cur;
    return v | hw_set;
  endfunction

endpackage

// File: rtl/fsc_regs.sv
module fsc_regs #(
  parameter int PAGE_W = 7,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              consume_page,
  input  logic              consume_mass,
  input  logic              preboot,
  input  logic [1:0]        flag_set,
  output logic              pwe_q,
  output logic              mass_en_q,
  output logic              secure_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_valid_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [1:0]        flags_q
);
  import fsc_pkg::*;

  logic wr_ctrl, wr_page, wr_bank, wr_flags;

  assign wr_ctrl  = sfr_wr && (sfr_addr == A_CTRL);
  assign wr_page  = sfr_wr && (sfr_addr == A_PAGE);
  assign wr_bank  = sfr_wr && (sfr_addr == A_BANK);
  assign wr_flags = sfr_wr && (sfr_addr == A_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwe_q        <= 1'b0;
      mass_en_q    <= 1'b0;
      secure_q     <= 1'b0;
      page_q       <= '0;
      page_valid_q <= 1'b0;
      bank_q       <= '0;
      flags_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        pwe_q     <= sfr_wdata[CB_PWE];
        mass_en_q <= sfr_wdata[CB_MASS];
        secure_q  <= secure_q | sfr_wdata[CB_SECURE];
      end else if (consume_mass) begin
        mass_en_q <= 1'b0;
      end
      if (wr_page) begin
        page_q       <= sfr_wdata[PAGE_W-1:0];
        page_valid_q <= 1'b1;
      end else if (consume_page) begin
        page_valid_q <= 1'b0;
      end
      if (wr_bank) bank_q <= sfr_wdata[BANK_W-1:0];
      flags_q <= flag_next(flags_q, wr_flags, sfr_wdata[1:0], flag_set);
    end
  end

  always_comb begin
    case (sfr_addr)
      A_CTRL:  sfr_rdata = {preboot, secure_q, 4'b0000, mass_en_q, pwe_q};
      A_PAGE:  sfr_rdata = 8'(page_q);
      A_BANK:  sfr_rdata = 8'(bank_q);
      A_FLAGS: sfr_rdata = {6'b000000, flags_q};
      default: sfr_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/fsc_erase.sv
module fsc_erase (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_wr,
  input  logic mass_armed,
  input  logic page_armed,
  input  logic done,
  output logic fire_page,
  output logic fire_mass,
  output logic active,
  output logic page_start_q,
  output logic mass_start_q,
  output logic busy_q
);
  import fsc_pkg::*;

  erase_kind_e kind;

  assign kind      = pick_erase(trig_wr, busy_q, mass_armed, page_armed);
  assign fire_page = (kind == ER_PAGE);
  assign fire_mass = (kind == ER_MASS);
  assign active    = busy_q | fire_page | fire_mass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_start_q <= 1'b0;
      mass_start_q <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      page_start_q <= fire_page;
      mass_start_q <= fire_mass;
      if (fire_page || fire_mass) busy_q <= 1'b1;
      else if (done)              busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fsc_xwrite.sv
module fsc_xwrite #(
  parameter int XA_W   = 16,
  parameter int BANK_W = 3,
  localparam int WA_W  = BANK_W + XA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xw_en,
  input  logic [XA_W-1:0]   xw_addr,
  input  logic [7:0]        xw_data,
  input  logic              pwe,
  input  logic [BANK_W-1:0] bank,
  input  logic              blocked,
  input  logic              ce_busy,
  input  logic              ce_pass_start,
  output logic              ram_we_q,
  output logic              flash_req_q,
  output logic [WA_W-1:0]   wr_addr_q,
  output logic [7:0]        wr_data_q,
  output logic [1:0]        coll_set
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we_q    <= 1'b0;
      flash_req_q <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      ram_we_q    <= xw_en && !pwe;
      flash_req_q <= xw_en && pwe && !blocked;
      if (xw_en) begin
        wr_addr_q <= {bank, xw_addr};
        wr_data_q <= xw_data;
      end
    end
  end

  // bit 0: issued flash write overlaps engine busy; bit 1: attempt on pass start
  assign coll_set = {xw_en && pwe && ce_pass_start, flash_req_q && ce_busy};

endmodule

// File: rtl/flash_sfr_ctl.sv
module flash_sfr_ctl #(
  parameter int PAGE_W = 7,
  parameter int BANK_W = 3,
  parameter int XA_W   = 16,
  localparam int WA_W  = BANK_W + XA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              xw_en,
  input  logic [XA_W-1:0]   xw_addr,
  input  logic [7:0]        xw_data,
  output logic              ram_we,
  output logic              flash_wr_req,
  output logic [WA_W-1:0]   wr_addr,
  output logic [7:0]        wr_data,
  output logic [PAGE_W-1:0] erase_page,
  output logic              page_erase_start,
  output logic              mass_erase_start,
  output logic              erase_busy,
  input  logic              erase_done,
  input  logic              ce_busy,
  input  logic              ce_pass_start,
  input  logic              preboot,
  input  logic [7:0]        flash_rd_data,
  output logic [7:0]        ext_rd_data
);
  import fsc_pkg::*;

  logic              trig_wr;
  logic              fire_page, fire_mass, erase_active;
  logic              pwe_q, mass_en_q, secure_q, page_valid_q;
  logic [PAGE_W-1:0] page_q;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        flags_q;
  logic [1:0]        coll_set;

  assign trig_wr = sfr_wr && (sfr_addr == A_TRIG);

  fsc_regs #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .consume_page(fire_page), .consume_mass(fire_mass),
    .preboot(preboot), .flag_set(coll_set),
    .pwe_q(pwe_q), .mass_en_q(mass_en_q), .secure_q(secure_q),
    .page_q(page_q), .page_valid_q(page_valid_q), .bank_q(bank_q), .flags_q(flags_q)
  );

  fsc_erase u_erase (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr),
    .mass_armed(mass_en_q), .page_armed(page_valid_q), .done(erase_done),
    .fire_page(fire_page), .fire_mass(fire_mass), .active(erase_active),
    .page_start_q(page_erase_start), .mass_start_q(mass_erase_start), .busy_q(erase_busy)
  );

  fsc_xwrite #(.XA_W(XA_W), .BANK_W(BANK_W)) u_xwrite (
    .clk(clk), .rst_n(rst_n),
    .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
    .pwe(pwe_q), .bank(bank_q), .blocked(erase_active),
    .ce_busy(ce_busy), .ce_pass_start(ce_pass_start),
    .ram_we_q(ram_we), .flash_req_q(flash_wr_req),
    .wr_addr_q(wr_addr), .wr_data_q(wr_data), .coll_set(coll_set)
  );

  assign erase_page  = page_q;
  assign ext_rd_data = secure_q ? 8'h00 : flash_rd_data;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int BANK_W = 3,
  parameter int XA_W   = 16,
  localparam int WA_W  = BANK_W + XA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_wr,
  input logic [7:0]        sfr_addr,
  input logic              page_erase_start,
  input logic              mass_erase_start,
  input logic              erase_busy,
  input logic              ram_we,
  input logic              flash_wr_req,
  input logic [WA_W-1:0]   wr_addr,
  input logic              secure_q,
  input logic              mass_en_q,
  input logic              page_valid_q,
  input logic [BANK_W-1:0] bank_q,
  input logic [1:0]        flags_q
);
  import fsc_pkg::*;

  p_one_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_erase_start && mass_erase_start));

  p_page_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_start |=> !page_erase_start);

  p_mass_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_start |-> !mass_en_q);

  p_mass_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_start |=> !mass_erase_start);

  p_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    page_erase_start |-> !page_valid_q);

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (page_erase_start || mass_erase_start) |-> erase_busy);

  p_no_flash_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !flash_wr_req);

  p_steer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && flash_wr_req));

  p_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flash_wr_req |-> (wr_addr[WA_W-1 -: BANK_W] == $past(bank_q)));

  p_secure_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    secure_q |=> secure_q);

  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[0] && !(sfr_wr && sfr_addr == A_FLAGS)) |=> flags_q[0]);

endmodule

bind flash_sfr_ctl fsc_checker #(.BANK_W(BANK_W), .XA_W(XA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .page_erase_start(page_erase_start), .mass_erase_start(mass_erase_start),
  .erase_busy(erase_busy), .ram_we(ram_we), .flash_wr_req(flash_wr_req),
  .wr_addr(wr_addr), .secure_q(secure_q), .mass_en_q(mass_en_q),
  .page_valid_q(page_valid_q), .bank_q(bank_q), .flags_q(flags_q)
);

// File: tb/tb_flash_sfr_ctl.sv
module tb_flash_sfr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 7;
  localparam int BANK_W = 3;
  localparam int XA_W   = 16;
  localparam int WA_W   = BANK_W + XA_W;
  localparam logic [7:0] CTRL = 8'h10, PAGE = 8'h11, BANK = 8'h12, TRIG = 8'h13, FLAGS = 8'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic xw_en = 1'b0;
  logic [XA_W-1:0] xw_addr = '0;
  logic [7:0] xw_data = 8'h00;
  logic ram_we, flash_wr_req;
  logic [WA_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [PAGE_W-1:0] erase_page;
  logic page_erase_start, mass_erase_start, erase_busy;
  logic erase_done = 1'b0, ce_busy = 1'b0, ce_pass_start = 1'b0, preboot = 1'b1;
  logic [7:0] flash_rd_data = 8'h00, ext_rd_data;

  int checks = 0, fails = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sfr_ctl #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .XA_W(XA_W)) dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
    .ram_we(ram_we), .flash_wr_req(flash_wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_page(erase_page), .page_erase_start(page_erase_start),
    .mass_erase_start(mass_erase_start), .erase_busy(erase_busy), .erase_done(erase_done),
    .ce_busy(ce_busy), .ce_pass_start(ce_pass_start), .preboot(preboot),
    .flash_rd_data(flash_rd_data), .ext_rd_data(ext_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic xwrite(input logic [XA_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    xw_en = 1'b1; xw_addr = a; xw_data = d;
    @(negedge clk);
    xw_en = 1'b0;
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    sfr_read(CTRL, rd);  chk("R1 ctrl", rd, 8'h80);
    sfr_read(PAGE, rd);  chk("R1 page", rd, 8'h00);
    sfr_read(BANK, rd);  chk("R1 bank", rd, 8'h00);
    sfr_read(FLAGS, rd); chk("R1 flags", rd, 8'h00);
    sfr_read(8'h3F, rd); chk("R1 unmapped", rd, 8'h00);
    chk("R1 busy", erase_busy, 1'b0);

    // R13 preboot read-only
    sfr_write(CTRL, 8'h00);
    sfr_read(CTRL, rd); chk("R13 write ignored", rd[7], 1'b1);
    preboot = 1'b0;
    sfr_read(CTRL, rd); chk("R13 follows input", rd[7], 1'b0);
    preboot = 1'b1;

    // R5 trigger with nothing armed
    sfr_write(TRIG, 8'h00);
    chk("R5 no page pulse", page_erase_start, 1'b0);
    chk("R5 no mass pulse", mass_erase_start, 1'b0);
    chk("R5 not busy", erase_busy, 1'b0);

    // R2/R3 sweep every page
    for (int p = 0; p < (1 << PAGE_W); p++) begin
      sfr_write(PAGE, 8'(p));
      sfr_read(PAGE, rd); chk("R2 page readback", rd, p);
      sfr_write(TRIG, 8'h00);
      chk("R2 page pulse", page_erase_start, 1'b1);
      chk("R2 no mass", mass_erase_start, 1'b0);
      chk("R2 erase_page", erase_page, p);
      @(negedge clk);
      chk("R2 pulse one cycle", page_erase_start, 1'b0);
      chk("R6 busy held", erase_busy, 1'b1);
      finish_erase();
      chk("R6 busy released", erase_busy, 1'b0);
      sfr_write(TRIG, 8'h00);
      chk("R3 rearm required", page_erase_start, 1'b0);
      chk("R3 no busy", erase_busy, 1'b0);
    end

    // R4 mass priority and consumption
    sfr_write(PAGE, 8'h05);
    sfr_write(CTRL, 8'h02);
    sfr_read(CTRL, rd); chk("R4 mass armed", rd[1], 1'b1);
    sfr_write(TRIG, 8'h00);
    chk("R4 mass pulse", mass_erase_start, 1'b1);
    chk("R4 no page pulse", page_erase_start, 1'b0);
    sfr_read(CTRL, rd); chk("R4 mass cleared", rd[1], 1'b0);
    finish_erase();
    sfr_write(TRIG, 8'h00);
    chk("R4 page still armed", page_erase_start, 1'b1);
    chk("R4 page value", erase_page, 7'h05);
    finish_erase();
    sfr_write(TRIG, 8'h00);
    chk("R3 all consumed", page_erase_start | mass_erase_start, 1'b0);

    // R6 blocking while busy
    sfr_write(PAGE, 8'h09);
    sfr_write(TRIG, 8'h00);
    chk("R6 start", page_erase_start, 1'b1);
    sfr_write(CTRL, 8'h03);
    sfr_write(TRIG, 8'h00);
    chk("R6 trigger blocked", mass_erase_start, 1'b0);
    sfr_read(CTRL, rd); chk("R6 arming kept", rd[1], 1'b1);
    xwrite(16'h0100, 8'hA5);
    chk("R6 flash write blocked", flash_wr_req, 1'b0);
    chk("R6 no ram write", ram_we, 1'b0);
    finish_erase();
    sfr_write(TRIG, 8'h00);
    chk("R6 after done", mass_erase_start, 1'b1);
    finish_erase();

    // R7/R8 bank sweep with flash writes
    sfr_write(CTRL, 8'h01);
    for (int b = 0; b < (1 << BANK_W); b++) begin
      sfr_write(BANK, 8'(b));
      sfr_read(BANK, rd); chk("R8 bank readback", rd, b);
      xwrite(16'h1234 + 16'(b), 8'(b * 3 + 1));
      chk("R7 flash req", flash_wr_req, 1'b1);
      chk("R7 no ram", ram_we, 1'b0);
      chk("R8 address", wr_addr, {3'(b), 16'h1234 + 16'(b)});
      chk("R7 data", wr_data, 8'(b * 3 + 1));
    end
    sfr_write(CTRL, 8'h00);
    xwrite(16'h0042, 8'h77);
    chk("R7 ram we", ram_we, 1'b1);
    chk("R7 no flash", flash_wr_req, 1'b0);
    chk("R7 ram data", wr_data, 8'h77);
    @(negedge clk);
    chk("R7 ram pulse one cycle", ram_we, 1'b0);

    // R10 collision with busy engine
    sfr_write(CTRL, 8'h01);
    ce_busy = 1'b1;
    xwrite(16'h0010, 8'h11);
    chk("R10 req issued", flash_wr_req, 1'b1);
    @(negedge clk);
    ce_busy = 1'b0;
    sfr_read(FLAGS, rd); chk("R10 flag0", rd, 8'h01);

    // R11 collision with pass start
    ce_pass_start = 1'b1;
    xwrite(16'h0020, 8'h22);
    ce_pass_start = 1'b0;
    sfr_read(FLAGS, rd); chk("R11 flag1", rd, 8'h03);

    // R12 clearing
    sfr_write(FLAGS, 8'h02);
    sfr_read(FLAGS, rd); chk("R12 clear bit0 only", rd, 8'h02);
    @(negedge clk);
    sfr_read(FLAGS, rd); chk("R12 sticky", rd, 8'h02);
    sfr_write(FLAGS, 8'h00);
    sfr_read(FLAGS, rd); chk("R12 cleared", rd, 8'h00);

    // R9 security latch
    flash_rd_data = 8'h5A;
    #1; chk("R9 open readout", ext_rd_data, 8'h5A);
    sfr_write(CTRL, 8'h00);
    sfr_read(CTRL, rd); chk("R9 still clear", rd[6], 1'b0);
    sfr_write(CTRL, 8'h40);
    sfr_read(CTRL, rd); chk("R9 set", rd[6], 1'b1);
    chk("R9 blanked", ext_rd_data, 8'h00);
    sfr_write(CTRL, 8'h00);
    sfr_read(CTRL, rd); chk("R9 zero ignored", rd[6], 1'b1);
    flash_rd_data = 8'hC3;
    #1; chk("R9 still blanked", ext_rd_data, 8'h00);

    summary();
    $finish;
  end

endmodule